// File: doc/BRIEF.md
# Tiered Write-Once Configuration Lock

This block sits between a register write port and a set of timer configuration fields. It stores the fields itself and decides, field by field, whether each incoming write may change them. The decision rests on a two-bit protection level. The level can only climb in steps from 0 to 3, and each step shields more fields than the one below it. The polarity and output-compare groups are shielded only for channels that are currently configured as outputs.

The protection level is set by the very first write to the core word after reset and is frozen from then on. This holds even when that first write carries level 0. A blocked write leaves the guarded field untouched, while the unguarded fields in the same word still take the new data. Every write is judged against the level that was in force before the write. Software can therefore set the level and the values it protects in one access. The timer functions that consume the fields are outside this block.

Top module: `cfg_lock_filter`

## Requirements
- R1: While the level is 0, a write to any word stores its data in every field of that word on the next clock edge.
- R2: At level 1 or above, writes leave the dead-time code, the idle-state bits, the break enable, the break polarity and the automatic output enable unchanged.
- R3: At level 2 or above, writes leave the run and idle off-state selects unchanged. They also leave the two polarity bits of every channel whose `chan_out` bit is 1 unchanged. Polarity bits of non-output channels stay writable.
- R4: At level 3, writes leave the output-compare mode and preload of every channel whose `chan_out` bit is 1 unchanged. The same fields of other channels stay writable.
- R5: The level takes bits 14:13 of the first write to address 0 after reset. After that write it never changes until reset, even if the value written was 0.
- R6: When a write is partly blocked, the fields it may change in the same word still update.
- R7: A write that sets the level is judged against the level in force before it. The first core write after reset therefore also stores its dead-time, break and off-state fields.
- R8: Reset makes the level, the first-write flag and every stored field 0.
- R9: Word map, by address:
  - Address 0: dead-time code in bits 7:0, break enable in bit 8, break polarity in bit 9, automatic output enable in bit 10, idle off-state in bit 11, run off-state in bit 12, level in bits 14:13.
  - Address 1: idle-state bits in bits 2*NCH-1:0.
  - Address 2: for channel c, polarity in bits 2c+1:2c.
  - Address 3: for channel c, mode in bits 4c+2:4c and preload in bit 4c+3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write strobe |
| wr_addr | input | 2 | Word address |
| wr_data | input | DATA_W | Write data |
| chan_out | input | NCH | Per-channel output-mode indication |
| lock_level | output | 2 | Current protection level |
| dt_code | output | 8 | Stored dead-time code |
| brk_en | output | 1 | Stored break enable |
| brk_pol | output | 1 | Stored break polarity |
| auto_oe | output | 1 | Stored automatic output enable |
| off_idle | output | 1 | Stored idle off-state select |
| off_run | output | 1 | Stored run off-state select |
| idle_state | output | 2*NCH | Stored idle-state bits |
| ch_pol | output | 2*NCH | Stored polarity bits, two per channel |
| oc_mode | output | 3*NCH | Stored output-compare mode, three per channel |
| oc_pre | output | NCH | Stored output-compare preload, one per channel |

## Verification
Random writes are applied at each of the four levels. Each run first resets and then sets a random level. The output-mode mask is random on every write, which separates channel-qualified protection from word-wide protection. Directed cases cover several situations:
- A first write of level 0 followed by a later attempt to raise the level, which shows the freeze is keyed to the first write and not to a nonzero value.
- A single write that sets level 3 along with new field data, which shows that the old level is used.
- A partly blocked core write, which shows that the unguarded bits in the same word still update.

// File: rtl/cfg_lock_pkg.sv
package cfg_lock_pkg;
  typedef enum logic [1:0] {
    LVL_OPEN  = 2'd0,
    LVL_BASIC = 2'd1,
    LVL_MID   = 2'd2,
    LVL_FULL  = 2'd3
  } lock_lvl_e;

  localparam int ADDR_W = 2;
  localparam logic [ADDR_W-1:0] A_CORE = 2'd0;
  localparam logic [ADDR_W-1:0] A_IDLE = 2'd1;
  localparam logic [ADDR_W-1:0] A_POL  = 2'd2;
  localparam logic [ADDR_W-1:0] A_OCC  = 2'd3;

  localparam int CORE_DT_LSB  = 0;
  localparam int CORE_DT_W    = 8;
  localparam int CORE_BE      = 8;
  localparam int CORE_BP      = 9;
  localparam int CORE_AOE     = 10;
  localparam int CORE_OSI     = 11;
  localparam int CORE_OSR     = 12;
  localparam int CORE_LVL_LSB = 13;
  localparam int CORE_USED    = 15;
endpackage

// File: rtl/cfg_lock_level.sv
module cfg_lock_level
  import cfg_lock_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      wr_core,
  input  logic [1:0] lvl_in,
  output lock_lvl_e lvl
);
  lock_lvl_e lvl_q, lvl_d;
  logic      once_q, once_d;
  logic      lvl_ce;

  always_comb begin
    lvl_ce = wr_core & ~once_q;
    lvl_d  = lvl_ce ? lock_lvl_e'(lvl_in) : lvl_q;
    once_d = once_q | wr_core;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lvl_q  <= LVL_OPEN;
      once_q <= 1'b0;
    end else begin
      lvl_q  <= lvl_d;
      once_q <= once_d;
    end
  end

  assign lvl = lvl_q;
endmodule

// File: rtl/cfg_lock_gate.sv
module cfg_lock_gate
  import cfg_lock_pkg::*;
#(
  parameter int NCH = 2
) (
  input  lock_lvl_e      lvl,
  input  logic [NCH-1:0] chan_out,
  output logic           core_open,
  output logic           off_open,
  output logic [NCH-1:0] pol_open,
  output logic [NCH-1:0] occ_open
);
  always_comb begin
    core_open = (lvl == LVL_OPEN);
    off_open  = (lvl == LVL_OPEN) || (lvl == LVL_BASIC);
  end

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    always_comb begin
      pol_open[c] = off_open || !chan_out[c];
      occ_open[c] = (lvl != LVL_FULL) || !chan_out[c];
    end
  end
endmodule

// File: rtl/cfg_lock_chan.sv
module cfg_lock_chan (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       pol_ce,
  input  logic       occ_ce,
  input  logic [1:0] pol_d,
  input  logic [3:0] occ_d,
  output logic [1:0] pol_q,
  output logic [2:0] mode_q,
  output logic       pre_q
);
  logic [1:0] pol_n;
  logic [2:0] mode_n;
  logic       pre_n;

  always_comb begin
    pol_n  = pol_ce ? pol_d : pol_q;
    mode_n = occ_ce ? occ_d[2:0] : mode_q;
    pre_n  = occ_ce ? occ_d[3] : pre_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pol_q  <= 2'b00;
      mode_q <= 3'b000;
      pre_q  <= 1'b0;
    end else begin
      pol_q  <= pol_n;
      mode_q <= mode_n;
      pre_q  <= pre_n;
    end
  end
endmodule

// File: rtl/cfg_lock_filter.sv
module cfg_lock_filter
  import cfg_lock_pkg::*;
#(
  parameter int NCH    = 2,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [1:0]        wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [NCH-1:0]    chan_out,
  output logic [1:0]        lock_level,
  output logic [7:0]        dt_code,
  output logic              brk_en,
  output logic              brk_pol,
  output logic              auto_oe,
  output logic              off_idle,
  output logic              off_run,
  output logic [2*NCH-1:0]  idle_state,
  output logic [2*NCH-1:0]  ch_pol,
  output logic [3*NCH-1:0]  oc_mode,
  output logic [NCH-1:0]    oc_pre
);
  localparam int IDLE_W = 2 * NCH;

  lock_lvl_e      lvl;
  logic           wr_core, wr_idle, wr_pol, wr_occ;
  logic           core_open, off_open;
  logic [NCH-1:0] pol_open, occ_open;
  logic           unused_data;

  assign unused_data = ^wr_data[DATA_W-1:CORE_USED];

  always_comb begin
    wr_core = wr_en && (wr_addr == A_CORE);
    wr_idle = wr_en && (wr_addr == A_IDLE);
    wr_pol  = wr_en && (wr_addr == A_POL);
    wr_occ  = wr_en && (wr_addr == A_OCC);
  end

  cfg_lock_level u_level (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_core (wr_core),
    .lvl_in  (wr_data[CORE_LVL_LSB +: 2]),
    .lvl     (lvl)
  );

  cfg_lock_gate #(.NCH(NCH)) u_gate (
    .lvl       (lvl),
    .chan_out  (chan_out),
    .core_open (core_open),
    .off_open  (off_open),
    .pol_open  (pol_open),
    .occ_open  (occ_open)
  );

  // Core and idle fields: next-state logic with explicit enables
  logic             core_ce, off_ce, idle_ce;
  logic [7:0]       dt_n;
  logic             be_n, bp_n, aoe_n, osi_n, osr_n;
  logic [IDLE_W-1:0] idle_n;

  always_comb begin
    core_ce = wr_core && core_open;
    off_ce  = wr_core && off_open;
    idle_ce = wr_idle && core_open;
    dt_n    = core_ce ? wr_data[CORE_DT_LSB +: CORE_DT_W] : dt_code;
    be_n    = core_ce ? wr_data[CORE_BE]  : brk_en;
    bp_n    = core_ce ? wr_data[CORE_BP]  : brk_pol;
    aoe_n   = core_ce ? wr_data[CORE_AOE] : auto_oe;
    osi_n   = off_ce  ? wr_data[CORE_OSI] : off_idle;
    osr_n   = off_ce  ? wr_data[CORE_OSR] : off_run;
    idle_n  = idle_ce ? wr_data[IDLE_W-1:0] : idle_state;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dt_code    <= '0;
      brk_en     <= 1'b0;
      brk_pol    <= 1'b0;
      auto_oe    <= 1'b0;
      off_idle   <= 1'b0;
      off_run    <= 1'b0;
      idle_state <= '0;
    end else begin
      dt_code    <= dt_n;
      brk_en     <= be_n;
      brk_pol    <= bp_n;
      auto_oe    <= aoe_n;
      off_idle   <= osi_n;
      off_run    <= osr_n;
      idle_state <= idle_n;
    end
  end

  for (genvar c = 0; c < NCH; c++) begin : g_chan
    cfg_lock_chan u_chan (
      .clk    (clk),
      .rst_n  (rst_n),
      .pol_ce (wr_pol && pol_open[c]),
      .occ_ce (wr_occ && occ_open[c]),
      .pol_d  (wr_data[2*c +: 2]),
      .occ_d  (wr_data[4*c +: 4]),
      .pol_q  (ch_pol[2*c +: 2]),
      .mode_q (oc_mode[3*c +: 3]),
      .pre_q  (oc_pre[c])
    );
  end

  assign lock_level = lvl;
endmodule

// File: rtl/cfg_lock_filter_chk.sv
module cfg_lock_filter_chk
  import cfg_lock_pkg::*;
#(
  parameter int NCH    = 2,
  parameter int DATA_W = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              wr_en,
  input logic [1:0]        wr_addr,
  input logic [DATA_W-1:0] wr_data,
  input logic [NCH-1:0]    chan_out,
  input logic [1:0]        lock_level,
  input logic [7:0]        dt_code,
  input logic              brk_en,
  input logic              brk_pol,
  input logic              auto_oe,
  input logic              off_idle,
  input logic              off_run,
  input logic [2*NCH-1:0]  idle_state,
  input logic [2*NCH-1:0]  ch_pol,
  input logic [3*NCH-1:0]  oc_mode,
  input logic [NCH-1:0]    oc_pre
);
  logic seen_core;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) seen_core <= 1'b0;
    else if (wr_en && wr_addr == A_CORE) seen_core <= 1'b1;
  end

  a_r5_zero_until_set: assert property (@(posedge clk) disable iff (!rst_n)
    !seen_core |-> lock_level == 2'd0);

  a_r5_level_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    seen_core |=> $stable(lock_level));

  a_r2_basic_held: assert property (@(posedge clk) disable iff (!rst_n)
    (lock_level != 2'd0) |=> ($stable(dt_code) && $stable(idle_state) &&
                              $stable(brk_en) && $stable(brk_pol) && $stable(auto_oe)));

  a_r3_off_held: assert property (@(posedge clk) disable iff (!rst_n)
    (lock_level >= 2'd2) |=> ($stable(off_run) && $stable(off_idle)));

  a_r1_open_core_write: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_addr == A_CORE && lock_level == 2'd0) |=>
      (dt_code == $past(wr_data[7:0]) && brk_en == $past(wr_data[CORE_BE])));

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    a_r3_pol_held: assert property (@(posedge clk) disable iff (!rst_n)
      (lock_level >= 2'd2 && chan_out[c]) |=> $stable(ch_pol[2*c +: 2]));

    a_r4_occ_held: assert property (@(posedge clk) disable iff (!rst_n)
      (lock_level == 2'd3 && chan_out[c]) |=> ($stable(oc_mode[3*c +: 3]) && $stable(oc_pre[c])));

    a_r3_pol_free: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_addr == A_POL && !chan_out[c]) |=> ch_pol[2*c +: 2] == $past(wr_data[2*c +: 2]));
  end
endmodule

bind cfg_lock_filter cfg_lock_filter_chk #(.NCH(NCH), .DATA_W(DATA_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .wr_en      (wr_en),
  .wr_addr    (wr_addr),
  .wr_data    (wr_data),
  .chan_out   (chan_out),
  .lock_level (lock_level),
  .dt_code    (dt_code),
  .brk_en     (brk_en),
  .brk_pol    (brk_pol),
  .auto_oe    (auto_oe),
  .off_idle   (off_idle),
  .off_run    (off_run),
  .idle_state (idle_state),
  .ch_pol     (ch_pol),
  .oc_mode    (oc_mode),
  .oc_pre     (oc_pre)
);

// File: tb/cfg_lock_filter_bench.sv
module cfg_lock_filter_bench;
  localparam int NCH = 2;
  localparam int DW  = 16;

  logic            clk = 1'b0;
  logic            rst_n;
  logic            wr_en;
  logic [1:0]      wr_addr;
  logic [DW-1:0]   wr_data;
  logic [NCH-1:0]  chan_out;
  logic [1:0]      lock_level;
  logic [7:0]      dt_code;
  logic            brk_en, brk_pol, auto_oe, off_idle, off_run;
  logic [2*NCH-1:0] idle_state, ch_pol;
  logic [3*NCH-1:0] oc_mode;
  logic [NCH-1:0]   oc_pre;

  always #4 clk = ~clk;

  cfg_lock_filter #(.NCH(NCH), .DATA_W(DW)) u_cfg_lock_filter (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .chan_out(chan_out), .lock_level(lock_level), .dt_code(dt_code), .brk_en(brk_en),
    .brk_pol(brk_pol), .auto_oe(auto_oe), .off_idle(off_idle), .off_run(off_run),
    .idle_state(idle_state), .ch_pol(ch_pol), .oc_mode(oc_mode), .oc_pre(oc_pre)
  );

  int n_run = 0;
  int n_fail = 0;
  bit finished = 1'b0;

  // Reference state
  logic [1:0]       m_lvl;
  bit               m_once;
  logic [7:0]       m_dt;
  logic             m_be, m_bp, m_aoe, m_osi, m_osr;
  logic [2*NCH-1:0] m_idle, m_pol;
  logic [3*NCH-1:0] m_mode;
  logic [NCH-1:0]   m_pre;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic model_clear();
    m_lvl = 0; m_once = 0; m_dt = 0; m_be = 0; m_bp = 0; m_aoe = 0;
    m_osi = 0; m_osr = 0; m_idle = 0; m_pol = 0; m_mode = 0; m_pre = 0;
  endtask

  function automatic bit pol_locked(input logic [1:0] l, input bit o);
    return (l >= 2) && o;
  endfunction

  function automatic bit occ_locked(input logic [1:0] l, input bit o);
    return (l == 3) && o;
  endfunction

  task automatic model_write(input logic [1:0] a, input logic [DW-1:0] d, input logic [NCH-1:0] co);
    logic [1:0] l;
    l = m_lvl;
    case (a)
      2'd0: begin
        if (l == 0) begin
          m_dt = d[7:0]; m_be = d[8]; m_bp = d[9]; m_aoe = d[10];
        end
        if (l < 2) begin
          m_osi = d[11]; m_osr = d[12];
        end
        if (!m_once) m_lvl = d[14:13];
        m_once = 1;
      end
      2'd1: if (l == 0) m_idle = d[2*NCH-1:0];
      2'd2: for (int c = 0; c < NCH; c++)
              if (!pol_locked(l, co[c])) m_pol[2*c +: 2] = d[2*c +: 2];
      default: for (int c = 0; c < NCH; c++)
              if (!occ_locked(l, co[c])) begin
                m_mode[3*c +: 3] = d[4*c +: 3];
                m_pre[c] = d[4*c+3];
              end
    endcase
  endtask

  task automatic compare_all(input string ctx);
    chk({ctx, " R5 level"}, 32'(lock_level), 32'(m_lvl));
    chk({ctx, " R2 dead-time"}, 32'(dt_code), 32'(m_dt));
    chk({ctx, " R2 break/aoe"}, 32'({brk_en, brk_pol, auto_oe}), 32'({m_be, m_bp, m_aoe}));
    chk({ctx, " R2 idle"}, 32'(idle_state), 32'(m_idle));
    chk({ctx, " R3 off-state"}, 32'({off_idle, off_run}), 32'({m_osi, m_osr}));
    chk({ctx, " R3 polarity"}, 32'(ch_pol), 32'(m_pol));
    chk({ctx, " R4 oc"}, 32'({oc_mode, oc_pre}), 32'({m_mode, m_pre}));
  endtask

  task automatic do_reset();
    wr_en = 0; wr_addr = 0; wr_data = 0; chan_out = 0;
    rst_n = 0;
    repeat (2) @(posedge clk);
    #2 rst_n = 1;
    model_clear();
    @(posedge clk); #2;
  endtask

  task automatic wr(input logic [1:0] a, input logic [DW-1:0] d, input logic [NCH-1:0] co);
    wr_en = 1; wr_addr = a; wr_data = d; chan_out = co;
    @(posedge clk); #2;
    model_write(a, d, co);
    wr_en = 0;
  endtask

  initial begin
    void'($urandom(32'h5eed_1234));
    rst_n = 0;
    do_reset();
    // R8: everything zero after reset
    chk("R8 reset level", 32'(lock_level), 0);
    chk("R8 reset fields", 32'({dt_code, brk_en, brk_pol, auto_oe, off_idle, off_run,
                                idle_state, ch_pol, oc_mode, oc_pre}), 0);

    // R1/R9: open writes to every word
    wr(2'd1, 16'h000A, 2'b11); chk("R1 idle write", 32'(idle_state), 32'h A);
    wr(2'd2, 16'h0009, 2'b11); chk("R1 pol write", 32'(ch_pol), 32'h9);
    wr(2'd3, 16'h00BD, 2'b11); chk("R9 oc mode", 32'(oc_mode), 32'({3'b011, 3'b101}));
    chk("R9 oc preload", 32'(oc_pre), 32'b11);

    // R7: first core write sets level 3 and fields together
    wr(2'd0, 16'h7FA5, 2'b11);
    chk("R7 level set", 32'(lock_level), 3);
    chk("R7 dead-time taken", 32'(dt_code), 32'hA5);
    chk("R7 off-state taken", 32'({off_idle, off_run}), 32'b11);
    // R5: second write cannot change level
    wr(2'd0, 16'h0000, 2'b00);
    chk("R5 frozen", 32'(lock_level), 3);
    chk("R2 dt held", 32'(dt_code), 32'hA5);
    // R4: non-output channel 1 writable, output channel 0 held
    wr(2'd3, 16'h0000, 2'b01);
    chk("R4 ch0 held", 32'({oc_mode[2:0], oc_pre[0]}), 32'({3'b101, 1'b1}));
    chk("R4 ch1 free", 32'({oc_mode[5:3], oc_pre[1]}), 0);

    // R5: first write of 0 still freezes
    do_reset();
    wr(2'd0, 16'h0011, 2'b00);
    wr(2'd0, 16'h6022, 2'b00);
    chk("R5 zero freeze", 32'(lock_level), 0);
    chk("R1 dt after zero", 32'(dt_code), 32'h22);

    // R6: level 1, partial core write
    do_reset();
    wr(2'd0, 16'h2033, 2'b00);
    wr(2'd0, 16'h1F44, 2'b00);
    chk("R6 dt blocked", 32'(dt_code), 32'h33);
    chk("R6 brk blocked", 32'({brk_en, brk_pol, auto_oe}), 0);
    chk("R6 off updated", 32'({off_idle, off_run}), 32'b11);

    // R3: level 2 mixed channel modes
    do_reset();
    wr(2'd0, 16'h4000, 2'b00);
    wr(2'd2, 16'h000F, 2'b10);
    chk("R3 pol ch0 free ch1 held", 32'(ch_pol), 32'h3);

    // Random rounds
    for (int r = 0; r < 12; r++) begin
      do_reset();
      compare_all("R8 rnd-reset");
      for (int k = 0; k < 80; k++) begin
        logic [1:0] a;
        logic [DW-1:0] d;
        logic [NCH-1:0] co;
        a  = 2'($urandom);
        d  = DW'($urandom);
        co = NCH'($urandom);
        if (k == 2) a = 2'd0;
        wr(a, d, co);
        compare_all("rnd");
      end
    end

    finished = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_run++;
      n_fail++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule